// File: doc/BRIEF.md
# Single-Buffered SPI Master with Transfer Hold-Off

This block is an SPI master that drives one 8-bit word at a time. It runs on the system clock and is programmed through a small register port. Software first sets the clock polarity, the clock phase, the SCK half-period and a slave-select pattern. It then writes one transmit byte. The block shifts that byte out MSB first on MOSI while it shifts in eight bits from MISO. When the word is done, every status and interrupt flag updates on a single system-clock edge.

A hold-off bit in the control register keeps a loaded word from starting. Software can use it to set up the select lines and the data before the first SCK edge. The select outputs work in one of two ways. In manual mode they follow the select register all the time. In automatic mode they follow it only while a word is in flight. If software writes all ones to the select register during a transfer, the word stops at once.

The completion edge is defined the same way in both phase modes. With phase 1 the last SCK period ends with no visible transition, so an internal tick provides that terminating edge.

Top module: `spi_inhibit_master`

Register map (3-bit address, 16-bit data):

| Address | Name | Fields |
|---|---|---|
| 0 | control | bit 0 polarity, bit 1 phase, bit 2 manual select, bit 8 transfer hold-off |
| 1 | select | active-low pattern, one bit per select line, reset all ones |
| 2 | transmit | bits 7:0 transmit byte; reads return the held byte |
| 3 | receive | bits 7:0 last received byte |
| 4 | status | bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full |
| 5 | divider | SCK half-period in system clocks; 0 acts as 1; reset 1 |
| 6 | interrupt | bit 1 word done, bit 4 receive full |

## Requirements
- R1: After reset, SCK is low, every select line is high, status reads 0x5, interrupt status reads 0, and the divider reads 1.
- R2: While no word is in flight, SCK sits at the polarity bit. During a word, SCK toggles every D system clocks, where D is the divider value and 0 counts as 1. A word has 16 toggles, and the first toggle comes D clocks after the start edge.
- R3: MOSI carries the transmit byte MSB first. With phase 0, MISO is sampled on odd toggles (leading edges) and MOSI moves on even toggles. With phase 1, MOSI moves on odd toggles from the third onward, and MISO is sampled on even toggles. The eight sampled bits, MSB first, form the received byte.
- R4: A word starts only when transmit full is set, the hold-off bit (control bit 8) is clear and at least one select bit is 0. While the hold-off bit is set, SCK stays idle and transmit full stays set.
- R5: In automatic mode (control bit 2 = 0), the select outputs equal the select register from the cycle after the start edge through the completion edge. At all other times they are all ones.
- R6: In manual mode (control bit 2 = 1), the select outputs equal the select register at all times. Transfer timing is unchanged.
- R7: On the completion edge the following all update together. Receive empty (status bit 0) clears, receive full (bit 1) sets, transmit empty (bit 2) sets and transmit full (bit 3) clears. Interrupt bits 4 and 1 set, and the receive register loads. The completion edge comes 16·D+1 clocks after the start edge with phase 0, and 17·D+1 clocks after it with phase 1.
- R8: A write to the transmit register while transmit full is set is ignored, and the held byte reads back unchanged.
- R9: Interrupt bits stay set until software writes 1 to them. Writing 0 leaves them unchanged, and a completion in the same cycle wins over a clear.
- R10: A read strobe on the receive register clears receive full and sets receive empty, unless a completion lands in the same cycle.
- R11: Writing all ones to the select register during a word aborts it. The engine goes idle, SCK returns to the polarity level, and no status or interrupt bit changes. The pending byte stays loaded and starts again once a select bit is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on receive register only) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
The abort path is the hardest case to reach from the ports. The select register has to return to all ones while the engine is partway through a word and the transmit byte is still held. Software can only reach the engine through register writes. The stimulus therefore loads a byte with a slow divider, waits a fixed number of clocks so the write lands mid-word, and writes all ones to the select register. It then re-selects, which shows that the same byte restarts from its first bit and completes. The bench holds the hold-off case the same way: it keeps control bit 8 set for many clocks after data is loaded, then clears it.

// File: rtl/spi_inh_pkg.sv
package spi_inh_pkg;

  localparam int WORD   = 8;
  localparam int EDGE_W = $clog2(2 * WORD + 2);
  localparam logic [EDGE_W-1:0] EDGES = EDGE_W'(2 * WORD);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_SEL  = 3'd1;
  localparam logic [2:0] A_TX   = 3'd2;
  localparam logic [2:0] A_RX   = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_DIV  = 3'd5;
  localparam logic [2:0] A_IRQ  = 3'd6;

  // index of the internal edge that closes a word
  function automatic logic [EDGE_W-1:0] last_edge(input logic cpha);
    return cpha ? EDGES + 1'b1 : EDGES;
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // half-period in clocks minus one; zero behaves as one
  function automatic logic [DIV_W-1:0] tick_limit(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  assign lim  = tick_limit(div);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_inh_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            start,
  input  logic            abort,
  input  logic            tick,
  input  logic [WORD-1:0] tx_byte,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [WORD-1:0] rx_byte
);

  localparam logic [EDGE_W-1:0] FIRST_LATE_SHIFT = EDGE_W'(3);
  localparam logic [EDGE_W-1:0] LAST_ODD         = EDGES - 1'b1;
  localparam logic [EDGE_W-1:0] LAST_EVEN_SHIFT  = EDGES - 2'd2;

  logic              busy_q, fin_q, sck_q;
  logic [EDGE_W-1:0] edge_q, edge_nx;
  logic [WORD-1:0]   tx_sr, rx_sr;

  // named internal events
  logic adv, toggle_hit, sample_hit, shift_hit, end_hit;

  assign edge_nx    = edge_q + 1'b1;
  assign adv        = busy_q && !fin_q && tick && !abort;
  assign toggle_hit = adv && (edge_nx <= EDGES);
  assign sample_hit = toggle_hit && (edge_nx[0] == !cpha);
  assign shift_hit  = adv && (cpha ? (edge_nx[0] && edge_nx >= FIRST_LATE_SHIFT && edge_nx <= LAST_ODD)
                                   : (!edge_nx[0] && edge_nx <= LAST_EVEN_SHIFT));
  assign end_hit    = adv && (edge_nx == last_edge(cpha));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      sck_q  <= 1'b0;
      edge_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      edge_q <= '0;
    end else if (fin_q) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      edge_q <= '0;
      sck_q  <= cpol;
      tx_sr  <= tx_byte;
    end else if (adv) begin
      edge_q <= edge_nx;
      if (toggle_hit) sck_q <= ~sck_q;
      if (shift_hit)  tx_sr <= {tx_sr[WORD-2:0], 1'b0};
      if (sample_hit) rx_sr <= {rx_sr[WORD-2:0], miso};
      if (end_hit)    fin_q <= 1'b1;
    end
  end

  assign sck     = busy_q ? sck_q : cpol;
  assign mosi    = tx_sr[WORD-1];
  assign busy    = busy_q;
  assign done    = fin_q && !abort;
  assign rx_byte = rx_sr;

  // R2
  sck_home_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> sck_q == cpol);

  // R7
  edge_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> edge_q == last_edge(cpha));

  // R11
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy_q);

endmodule

// File: rtl/spi_inhibit_master.sv
module spi_inhibit_master
  import spi_inh_pkg::*;
#(
  parameter int NSS   = 2,
  parameter int DIV_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [2:0]     reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic [15:0]    reg_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n
);

  logic             cpol_q, cpha_q, man_q, inh_q;
  logic [NSS-1:0]   sel_q;
  logic [DIV_W-1:0] div_q;
  logic [WORD-1:0]  tx_buf, rx_data_q, eng_rx;
  logic             tx_full_q, rx_full_q, irq_rx_q, irq_done_q;
  logic             eng_busy, eng_done, tick, start_req, abort;
  logic             wr_ctrl, wr_sel, wr_tx, wr_div, wr_irq, rd_rx;
  logic             unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata[15:9]};

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_sel  = reg_wr && (reg_addr == A_SEL);
  assign wr_tx   = reg_wr && (reg_addr == A_TX);
  assign wr_div  = reg_wr && (reg_addr == A_DIV);
  assign wr_irq  = reg_wr && (reg_addr == A_IRQ);
  assign rd_rx   = reg_rd && (reg_addr == A_RX);

  assign start_req = tx_full_q && !inh_q && (sel_q != '1);
  assign abort     = eng_busy && (sel_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      man_q  <= 1'b0;
      inh_q  <= 1'b0;
      sel_q  <= '1;
      div_q  <= DIV_W'(1);
    end else begin
      if (wr_ctrl) begin
        cpol_q <= reg_wdata[0];
        cpha_q <= reg_wdata[1];
        man_q  <= reg_wdata[2];
        inh_q  <= reg_wdata[8];
      end
      if (wr_sel) sel_q <= reg_wdata[NSS-1:0];
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf     <= '0;
      tx_full_q  <= 1'b0;
      rx_data_q  <= '0;
      rx_full_q  <= 1'b0;
      irq_rx_q   <= 1'b0;
      irq_done_q <= 1'b0;
    end else begin
      if (eng_done)                tx_full_q <= 1'b0;
      else if (wr_tx && !tx_full_q) tx_full_q <= 1'b1;
      if (wr_tx && !tx_full_q) tx_buf <= reg_wdata[WORD-1:0];

      if (eng_done) begin
        rx_data_q <= eng_rx;
        rx_full_q <= 1'b1;
      end else if (rd_rx) begin
        rx_full_q <= 1'b0;
      end

      irq_rx_q   <= eng_done | (irq_rx_q   & ~(wr_irq & reg_wdata[4]));
      irq_done_q <= eng_done | (irq_done_q & ~(wr_irq & reg_wdata[1]));
    end
  end

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_busy),
    .div  (div_q),
    .tick (tick)
  );

  spi_shift_engine u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpol   (cpol_q),
    .cpha   (cpha_q),
    .start  (start_req),
    .abort  (abort),
    .tick   (tick),
    .tx_byte(tx_buf),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .busy   (eng_busy),
    .done   (eng_done),
    .rx_byte(eng_rx)
  );

  assign ss_n = (man_q || eng_busy) ? sel_q : '1;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = {7'b0, inh_q, 5'b0, man_q, cpha_q, cpol_q};
      A_SEL:  reg_rdata = 16'(sel_q);
      A_TX:   reg_rdata = 16'(tx_buf);
      A_RX:   reg_rdata = 16'(rx_data_q);
      A_STAT: reg_rdata = {12'b0, tx_full_q, !tx_full_q, rx_full_q, !rx_full_q};
      A_DIV:  reg_rdata = 16'(div_q);
      A_IRQ:  reg_rdata = {11'b0, irq_rx_q, 2'b0, irq_done_q, 1'b0};
      default: reg_rdata = '0;
    endcase
  end

  // R4
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(!inh_q));

  // R7
  flags_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (!tx_full_q && rx_full_q && irq_rx_q && irq_done_q));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full_q) |=> $stable(tx_buf));

endmodule

// File: tb/spi_inhibit_master_test.sv
module spi_inhibit_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [1:0]  ss_n;

  int vectors = 0, fails = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  spi_inhibit_master #(.NSS(2), .DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  // behavioural reference state
  bit       m_cpol, m_cpha, m_man, m_inh, m_txf, m_rxf, m_irq_rx, m_irq_done, m_busy;
  bit [1:0] m_sel = 2'b11;
  int       m_div = 1, m_n = 0;
  bit [7:0] m_tx, m_rx, m_txword, m_slave;

  function automatic int half(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int toggles();
    int t;
    if (!m_busy) return 0;
    t = m_n / half(m_div);
    return (t > 16) ? 16 : t;
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {7'b0, m_inh, 5'b0, m_man, m_cpha, m_cpol};
      3'd1: return {14'b0, m_sel};
      3'd2: return {8'b0, m_tx};
      3'd3: return {8'b0, m_rx};
      3'd4: return {12'b0, m_txf, !m_txf, m_rxf, !m_rxf};
      3'd5: return 16'(m_div);
      3'd6: return {11'b0, m_irq_rx, 2'b0, m_irq_done, 1'b0};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cpol = 0; m_cpha = 0; m_man = 0; m_inh = 0; m_sel = 2'b11; m_div = 1;
      m_tx = 0; m_txf = 0; m_rx = 0; m_rxf = 0; m_irq_rx = 0; m_irq_done = 0;
      m_busy = 0; m_n = 0;
    end else begin
      bit fin;
      bit otf;
      int lim;
      fin = 0;
      otf = m_txf;
      lim = (m_cpha ? 17 : 16) * half(m_div) + 1;
      if (m_busy) begin
        if (m_sel == 2'b11) m_busy = 0;
        else begin
          m_n++;
          if (m_n == lim) begin fin = 1; m_busy = 0; end
        end
      end else if (otf && !m_inh && m_sel != 2'b11) begin
        m_busy = 1; m_n = 0; m_txword = m_tx;
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin m_cpol = reg_wdata[0]; m_cpha = reg_wdata[1];
                      m_man = reg_wdata[2]; m_inh = reg_wdata[8]; end
          3'd1: m_sel = reg_wdata[1:0];
          3'd2: if (!otf) begin m_tx = reg_wdata[7:0]; m_txf = 1; end
          3'd5: m_div = int'(reg_wdata[7:0]);
          3'd6: begin if (reg_wdata[4]) m_irq_rx = 0; if (reg_wdata[1]) m_irq_done = 0; end
          default: ;
        endcase
      end
      if (reg_rd && reg_addr == 3'd3) m_rxf = 0;
      if (fin) begin
        m_txf = 0; m_rxf = 1; m_rx = m_slave; m_irq_rx = 1; m_irq_done = 1;
      end
    end
  end

  // per-clock comparison and slave MISO drive
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      int t, s, j;
      t = toggles();
      chk("R2 sck", {15'b0, sck}, {15'b0, m_busy ? (m_cpol ^ t[0]) : m_cpol});
      chk(m_man ? "R6 ss_n" : "R5 ss_n", {14'b0, ss_n},
          {14'b0, (m_man || m_busy) ? m_sel : 2'b11});
      if (m_busy) begin
        if (m_cpha) s = (t >= 3) ? (((t > 15) ? 15 : t) - 1) / 2 : 0;
        else        s = ((t > 14) ? 14 : t) / 2;
        chk("R3 mosi", {15'b0, mosi}, {15'b0, m_txword[7 - s]});
      end
      case (reg_addr)
        3'd4:    chk("R7 status", reg_rdata, exp_read(reg_addr));
        3'd6:    chk("R9 irq", reg_rdata, exp_read(reg_addr));
        3'd3:    chk("R10 rx", reg_rdata, exp_read(reg_addr));
        default: chk("R1 regs", reg_rdata, exp_read(reg_addr));
      endcase
      if (m_cpha) j = (t == 0) ? 0 : (t - 1) / 2;
      else        j = t / 2;
      if (j > 7) j = 7;
      miso = m_slave[7 - j];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 3'd4;
  endtask

  task automatic rd_rx();
    @(posedge clk); #1;
    reg_rd = 1; reg_addr = 3'd3;
    @(posedge clk); #1;
    reg_rd = 0; reg_addr = 3'd4;
  endtask

  task automatic peek(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    @(posedge clk); #1;
    reg_addr = 3'd4;
  endtask

  task automatic wait_done();
    @(posedge clk); #1;
    while (m_busy) begin @(posedge clk); #1; end
  endtask

  task automatic finish_word(input logic [7:0] slv);
    wait_done();
    peek(3'd4, 16'h0006, "R7 status after word");
    peek(3'd6, 16'h0012, "R7 irq after word");
    peek(3'd3, {8'b0, slv}, "R3 received byte");
    rd_rx();
    peek(3'd4, 16'h0005, "R10 status after read");
    wr(3'd6, 16'h0012);
  endtask

  task automatic word(input logic [15:0] ctrl, input logic [7:0] div,
                      input logic [7:0] txb, input logic [7:0] slv);
    wr(3'd5, {8'b0, div});
    wr(3'd0, ctrl);
    m_slave = slv;
    wr(3'd1, 16'h0002);
    wr(3'd2, {8'b0, txb});
    finish_word(slv);
  endtask

  task automatic summary();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sck", {15'b0, sck}, 16'h0);
    chk("R1 ss_n", {14'b0, ss_n}, 16'h3);
    peek(3'd4, 16'h0005, "R1 status");
    peek(3'd6, 16'h0000, "R1 irq");
    peek(3'd5, 16'h0001, "R1 divider");

    // mode 0, divider 2
    word(16'h0000, 8'd2, 8'hA5, 8'h3C);

    // R9 sticky flags, write-1-to-clear
    wr(3'd5, 16'd1); m_slave = 8'h11; wr(3'd1, 16'h0002); wr(3'd2, 16'h0055);
    wait_done();
    wr(3'd6, 16'h0000);
    peek(3'd6, 16'h0012, "R9 zero write keeps flags");
    wr(3'd6, 16'h0010);
    peek(3'd6, 16'h0002, "R9 clear bit 4 only");
    wr(3'd6, 16'h0002);
    peek(3'd6, 16'h0000, "R9 clear bit 1");
    rd_rx();

    // mode 3, divider 0 acts as 1; R8 write while full
    wr(3'd5, 16'd0); wr(3'd0, 16'h0003); m_slave = 8'hC3;
    wr(3'd2, 16'h005A);
    wr(3'd2, 16'h00FF);
    peek(3'd2, 16'h005A, "R8 held byte unchanged");
    finish_word(8'hC3);

    // mode 1 and mode 2
    word(16'h0002, 8'd3, 8'h1E, 8'h96);
    word(16'h0001, 8'd1, 8'hF0, 8'h0F);

    // R4 hold-off with manual select
    wr(3'd0, 16'h0104); wr(3'd5, 16'd2); m_slave = 8'h81;
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0042);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R4 sck idle while held", {15'b0, sck}, 16'h0);
    chk("R6 manual select asserted", {14'b0, ss_n}, 16'h1);
    peek(3'd4, 16'h0009, "R4 transmit still full");
    wr(3'd0, 16'h0004);
    finish_word(8'h81);
    @(negedge clk);
    chk("R6 select held after word", {14'b0, ss_n}, 16'h1);
    wr(3'd1, 16'h0003);

    // R11 abort mid-word and restart
    wr(3'd0, 16'h0000); wr(3'd5, 16'd4); m_slave = 8'hE7;
    wr(3'd1, 16'h0002);
    wr(3'd2, 16'h0077);
    repeat (20) @(posedge clk);
    wr(3'd1, 16'h0003);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 sck idle after abort", {15'b0, sck}, 16'h0);
    chk("R11 select released", {14'b0, ss_n}, 16'h3);
    peek(3'd6, 16'h0000, "R11 no irq on abort");
    peek(3'd4, 16'h0009, "R11 byte still pending");
    wr(3'd1, 16'h0002);
    finish_word(8'hE7);

    repeat (5) @(posedge clk);
    summary();
  end

endmodule